// File: doc/BRIEF.md
# Double-Data-Rate Input Capture Register

This block captures a data input on both edges of a single clock and presents the two samples on two single-rate outputs. The rising-edge sample goes to `q1`. The falling-edge sample goes to `q2`. The falling edge is sampled by an internally inverted copy of the one clock input; there is no second clock port. A mode parameter sets how the two samples line up in time. In the opposite-edge mode each output changes on its own capture edge. The two same-edge modes move the falling-edge sample into the rising-edge domain inside the block. One of them does this without a pipeline stage, and the other adds a stage so that both samples of one clock period appear together.

Every storage element has two control inputs that override data capture: `sr` and `rev`. Each element has its own per-element level parameter. `rev` forces the element to that level, and `sr` forces it to the complement. When both are high, `sr` wins. A single parameter makes all the controls synchronous (they act on each element's own clock edge) or asynchronous (they act as soon as they are raised). A clock enable freezes every element on both edges when it is low.

Top module: `ddr_in_capture`

## Requirements
- R1: In every mode except same-edge-pipelined, `q1` takes the value of `d` sampled at a rising edge and shows it just after that rising edge.
- R2: With `MODE` = 0 (opposite-edge), `q2` takes the value of `d` sampled at a falling edge and shows it just after that falling edge.
- R3: With `MODE` = 1 (same-edge), `q2` changes only on rising edges. After rising edge k, it holds the falling-edge sample taken between rising edges k-1 and k, while `q1` holds the rising-edge sample of edge k.
- R4: With `MODE` = 2 (same-edge-pipelined), after rising edge k `q1` holds the rising-edge sample of edge k-1 and `q2` holds the falling-edge sample that directly followed edge k-1. Both change only on rising edges.
- R5: While `sr` is high, every element is forced to the complement of its level parameter (all bits). This overrides both `rev` and `ce`.
- R6: While `rev` is high and `sr` is low, every element is forced to its level parameter (all bits). This overrides `ce`.
- R7: While `ce` is low and both controls are low, neither output changes on either clock edge, whatever `d` does.
- R8: With `SR_ASYNC` = 0, a raised control acts on an element only at that element's capture edge: rising for `q1`, falling for the opposite-edge `q2`. With `SR_ASYNC` = 1, it acts at once, without waiting for a clock edge.
- R9: The level parameters of the four elements are independent. An element with level 0 goes to all ones under `sr` and to all zeros under `rev`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single capture clock; its inverse samples the falling edge |
| ce | input | 1 | Clock enable for all storage elements, both edges |
| sr | input | 1 | Force-to-complement-of-level control, highest priority |
| rev | input | 1 | Force-to-level control |
| d | input | WIDTH | Double-data-rate input data |
| q1 | output | WIDTH | Rising-edge sample output |
| q2 | output | WIDTH | Falling-edge sample output |

## Verification
Four instances share one stimulus: opposite-edge synchronous, same-edge synchronous, pipelined asynchronous, and opposite-edge asynchronous with mixed levels. A stream gives `d` a distinct value on every edge, and the rising and falling values also differ from each other. A wrong pairing, a missing or extra stage, or a falling-edge update of `q2` in a same-edge mode therefore each produce a different wrong value. Raising the controls between edges separates synchronous from asynchronous action. Raising both controls together shows their priority. The mixed-level instances show that each element uses its own level. Changing `d` under a low enable on both edges shows that nothing is captured.

// File: rtl/ddr_cap_pkg.sv
`timescale 1ns/1ps
package ddr_cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OPPOSITE  = 2'd0,
        EDGE_SAME      = 2'd1,
        EDGE_SAME_PIPE = 2'd2
    } edge_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_REV,
        ACT_SR
    } cell_act_e;

    typedef struct packed {
        logic sr;
        logic rev;
        logic ce;
    } cell_ctl_t;

    function automatic cell_act_e decode_act(cell_ctl_t c);
        if (c.sr)       return ACT_SR;
        else if (c.rev) return ACT_REV;
        else if (c.ce)  return ACT_LOAD;
        else            return ACT_HOLD;
    endfunction

    function automatic bit mode_retimes(edge_mode_e m);
        return m != EDGE_OPPOSITE;
    endfunction

endpackage

// File: rtl/ddr_cap_cell.sv
`timescale 1ns/1ps
module ddr_cap_cell
    import ddr_cap_pkg::*;
#(
    parameter int WIDTH     = 1,
    parameter bit REV_LEVEL = 1'b1,
    parameter bit SR_ASYNC  = 1'b0
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sr,
    input  logic             rev,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] REV_WORD = {WIDTH{REV_LEVEL}};
    localparam logic [WIDTH-1:0] SR_WORD  = ~REV_WORD;

    cell_ctl_t        ctl;
    cell_act_e        act;
    logic [WIDTH-1:0] q_nxt;

    assign ctl = '{sr: sr, rev: rev, ce: ce};
    assign act = decode_act(ctl);

    always_comb begin
        unique case (act)
            ACT_SR:   q_nxt = SR_WORD;
            ACT_REV:  q_nxt = REV_WORD;
            ACT_LOAD: q_nxt = d;
            default:  q_nxt = q;
        endcase
    end

    generate
        if (SR_ASYNC) begin : g_async
            always_ff @(posedge clk or posedge sr or posedge rev) begin
                if (sr)       q <= SR_WORD;
                else if (rev) q <= REV_WORD;
                else          q <= q_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                q <= q_nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/ddr_rise_retime.sv
`timescale 1ns/1ps
module ddr_rise_retime
    import ddr_cap_pkg::*;
#(
    parameter int         WIDTH      = 1,
    parameter edge_mode_e MODE       = EDGE_SAME,
    parameter bit         SR_ASYNC   = 1'b0,
    parameter bit         REV_LVL_Q1 = 1'b1,
    parameter bit         REV_LVL_Q2 = 1'b1
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sr,
    input  logic             rev,
    input  logic [WIDTH-1:0] rise_s,
    input  logic [WIDTH-1:0] fall_s,
    output logic [WIDTH-1:0] q1,
    output logic [WIDTH-1:0] q2
);
    // Falling sample moved onto the rising edge (both same-edge modes)
    ddr_cap_cell #(
        .WIDTH(WIDTH), .REV_LEVEL(REV_LVL_Q2), .SR_ASYNC(SR_ASYNC)
    ) u_fall_rt (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(fall_s), .q(q2)
    );

    generate
        if (MODE == EDGE_SAME_PIPE) begin : g_pipe
            // Extra rising stage so both samples of one period align
            ddr_cap_cell #(
                .WIDTH(WIDTH), .REV_LEVEL(REV_LVL_Q1), .SR_ASYNC(SR_ASYNC)
            ) u_rise_pl (
                .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(rise_s), .q(q1)
            );
        end else begin : g_direct
            assign q1 = rise_s;
        end
    endgenerate

endmodule

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture
    import ddr_cap_pkg::*;
#(
    parameter int         WIDTH        = 1,
    parameter edge_mode_e MODE         = EDGE_OPPOSITE,
    parameter bit         SR_ASYNC     = 1'b0,
    parameter bit         REV_LVL_RISE = 1'b1,
    parameter bit         REV_LVL_FALL = 1'b1,
    parameter bit         REV_LVL_Q1   = 1'b1,
    parameter bit         REV_LVL_Q2   = 1'b1
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             sr,
    input  logic             rev,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q1,
    output logic [WIDTH-1:0] q2
);
    localparam bit RETIME = mode_retimes(MODE);

    logic             clk_n;
    logic [WIDTH-1:0] rise_s;
    logic [WIDTH-1:0] fall_s;

    // Local inversion: the falling edge becomes a rising edge of clk_n
    assign clk_n = ~clk;

    ddr_cap_cell #(
        .WIDTH(WIDTH), .REV_LEVEL(REV_LVL_RISE), .SR_ASYNC(SR_ASYNC)
    ) u_rise (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q(rise_s)
    );

    ddr_cap_cell #(
        .WIDTH(WIDTH), .REV_LEVEL(REV_LVL_FALL), .SR_ASYNC(SR_ASYNC)
    ) u_fall (
        .clk(clk_n), .ce(ce), .sr(sr), .rev(rev), .d(d), .q(fall_s)
    );

    generate
        if (RETIME) begin : g_same
            ddr_rise_retime #(
                .WIDTH(WIDTH), .MODE(MODE), .SR_ASYNC(SR_ASYNC),
                .REV_LVL_Q1(REV_LVL_Q1), .REV_LVL_Q2(REV_LVL_Q2)
            ) u_rt (
                .clk(clk), .ce(ce), .sr(sr), .rev(rev),
                .rise_s(rise_s), .fall_s(fall_s), .q1(q1), .q2(q2)
            );
        end else begin : g_opposite
            assign q1 = rise_s;
            assign q2 = fall_s;
        end
    endgenerate

endmodule

// File: rtl/ddr_in_capture_chk.sv
`timescale 1ns/1ps
module ddr_in_capture_chk
    import ddr_cap_pkg::*;
#(
    parameter int         WIDTH        = 1,
    parameter edge_mode_e MODE         = EDGE_OPPOSITE,
    parameter bit         SR_ASYNC     = 1'b0,
    parameter bit         REV_LVL_RISE = 1'b1,
    parameter bit         REV_LVL_FALL = 1'b1,
    parameter bit         REV_LVL_Q1   = 1'b1,
    parameter bit         REV_LVL_Q2   = 1'b1
) (
    input logic             clk,
    input logic             ce,
    input logic             sr,
    input logic             rev,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] q1,
    input logic [WIDTH-1:0] q2
);
    localparam bit OUT1_LVL = (MODE == EDGE_SAME_PIPE) ? REV_LVL_Q1 : REV_LVL_RISE;
    localparam bit OUT2_LVL = (MODE == EDGE_OPPOSITE)  ? REV_LVL_FALL : REV_LVL_Q2;
    localparam logic [WIDTH-1:0] Q1_REV = {WIDTH{OUT1_LVL}};
    localparam logic [WIDTH-1:0] Q2_REV = {WIDTH{OUT2_LVL}};
    localparam logic [WIDTH-1:0] Q1_SR  = ~Q1_REV;
    localparam logic [WIDTH-1:0] Q2_SR  = ~Q2_REV;

    bit [1:0]         edge_cnt;
    bit               fall_seen;
    logic [WIDTH-1:0] q2_at_fall;

    always_ff @(posedge clk) begin
        if (edge_cnt != 2'd3) edge_cnt <= edge_cnt + 2'd1;
    end

    always_ff @(negedge clk) begin
        fall_seen  <= 1'b1;
        q2_at_fall <= q2;
    end

    // R1: q1 follows the rising sample one edge later
    p_q1_rise_r1: assert property (@(posedge clk) disable iff (sr || rev)
        (MODE != EDGE_SAME_PIPE && edge_cnt >= 2'd1 && ce) |=> (q1 == $past(d)));

    // R4: pipelined q1 is the rising sample of the previous period
    p_q1_pipe_r4: assert property (@(posedge clk) disable iff (sr || rev)
        (MODE == EDGE_SAME_PIPE && edge_cnt >= 2'd2 && ce && $past(ce)
         && !$past(sr) && !$past(rev)) |=> (q1 == $past(d, 2)));

    // R3: in same-edge modes q2 never moves on a falling edge
    p_q2_rise_only_r3: assert property (@(posedge clk) disable iff (sr || rev)
        (MODE != EDGE_OPPOSITE && fall_seen) |-> (q2 == q2_at_fall));

    // R5: sr forces the complement of the level on q1
    p_sr_q1_r5: assert property (@(posedge clk)
        sr |=> (q1 == Q1_SR));

    // R5: sr forces the complement of the level on retimed q2
    p_sr_q2_r5: assert property (@(posedge clk)
        (sr && MODE != EDGE_OPPOSITE) |=> (q2 == Q2_SR));

    // R6: rev alone forces the level on q1 (synchronous variant)
    p_rev_q1_r6: assert property (@(posedge clk) disable iff (sr)
        (!SR_ASYNC && rev) |=> (q1 == Q1_REV));

    // R7: low enable freezes q1
    p_ce_hold_q1_r7: assert property (@(posedge clk) disable iff (sr || rev)
        (!SR_ASYNC && edge_cnt >= 2'd1 && !ce) |=> $stable(q1));

    // R7: low enable freezes retimed q2
    p_ce_hold_q2_r7: assert property (@(posedge clk) disable iff (sr || rev)
        (!SR_ASYNC && MODE != EDGE_OPPOSITE && edge_cnt >= 2'd1 && !ce) |=> $stable(q2));

endmodule

bind ddr_in_capture ddr_in_capture_chk #(
    .WIDTH(WIDTH), .MODE(MODE), .SR_ASYNC(SR_ASYNC),
    .REV_LVL_RISE(REV_LVL_RISE), .REV_LVL_FALL(REV_LVL_FALL),
    .REV_LVL_Q1(REV_LVL_Q1), .REV_LVL_Q2(REV_LVL_Q2)
) u_chk (
    .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q1(q1), .q2(q2)
);

// File: tb/tb_ddr_in_capture.sv
`timescale 1ns/1ps
module tb_ddr_in_capture;
    import ddr_cap_pkg::*;

    localparam int W = 2;

    logic         clk = 1'b0;
    logic         ce  = 1'b1;
    logic         sr  = 1'b1;
    logic         rev = 1'b0;
    logic [W-1:0] d   = '0;

    logic [W-1:0] q1_oe, q2_oe, q1_se, q2_se, q1_sp, q2_sp, q1_oa, q2_oa;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // opposite-edge, synchronous, all levels 1
    ddr_in_capture #(.WIDTH(W), .MODE(EDGE_OPPOSITE), .SR_ASYNC(1'b0)) dut (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q1(q1_oe), .q2(q2_oe));

    // same-edge, synchronous, all levels 1
    ddr_in_capture #(.WIDTH(W), .MODE(EDGE_SAME), .SR_ASYNC(1'b0)) dut_se (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q1(q1_se), .q2(q2_se));

    // pipelined, asynchronous, q1 stage level 0, q2 stage level 1
    ddr_in_capture #(.WIDTH(W), .MODE(EDGE_SAME_PIPE), .SR_ASYNC(1'b1),
        .REV_LVL_Q1(1'b0), .REV_LVL_Q2(1'b1)) dut_sp (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q1(q1_sp), .q2(q2_sp));

    // opposite-edge, asynchronous, rising level 0, falling level 1
    ddr_in_capture #(.WIDTH(W), .MODE(EDGE_OPPOSITE), .SR_ASYNC(1'b1),
        .REV_LVL_RISE(1'b0), .REV_LVL_FALL(1'b1)) dut_oa (
        .clk(clk), .ce(ce), .sr(sr), .rev(rev), .d(d), .q1(q1_oa), .q2(q2_oa));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R5: state held under sr after start-up
    task automatic t_reset_state();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R5 reset q1 opp-sync", 16'(q1_oe), 16'(2'b00));
        chk("R5 reset q2 opp-sync", 16'(q2_oe), 16'(2'b00));
        chk("R5 reset q1/q2 same", 16'({q1_se, q2_se}), 16'(4'b0000));
        chk("R9 reset q1 pipe lvl0", 16'(q1_sp), 16'(2'b11));
        chk("R5 reset q2 pipe", 16'(q2_sp), 16'(2'b00));
        chk("R9 reset q1 opp-async lvl0", 16'(q1_oa), 16'(2'b11));
        chk("R5 reset q2 opp-async", 16'(q2_oa), 16'(2'b00));
        sr = 1'b0;
    endtask

    // R1 R2 R3 R4: distinct value on every edge
    task automatic t_stream();
        logic [W-1:0] r_prev = '0;
        logic [W-1:0] f_prev = '0;
        @(negedge clk); #1;
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] r;
            logic [W-1:0] f;
            r = W'(i * 3 + 1);
            f = W'(i * 3 + 2);
            d = r;
            @(posedge clk); #1;
            chk("R1 q1 opp-sync", 16'(q1_oe), 16'(r));
            chk("R1 q1 opp-async", 16'(q1_oa), 16'(r));
            chk("R3 q1 same", 16'(q1_se), 16'(r));
            if (i > 0) begin
                chk("R3 q2 same prev fall", 16'(q2_se), 16'(f_prev));
                chk("R4 q1 pipe", 16'(q1_sp), 16'(r_prev));
                chk("R4 q2 pipe", 16'(q2_sp), 16'(f_prev));
            end
            d = f;
            @(negedge clk); #1;
            chk("R2 q2 opp-sync", 16'(q2_oe), 16'(f));
            chk("R2 q2 opp-async", 16'(q2_oa), 16'(f));
            if (i > 0) begin
                chk("R3 q2 same held at fall", 16'(q2_se), 16'(f_prev));
                chk("R4 q2 pipe held at fall", 16'(q2_sp), 16'(f_prev));
            end
            r_prev = r;
            f_prev = f;
        end
    endtask

    // R7: low enable freezes everything on both edges
    task automatic t_ce_hold();
        logic [15:0] snap;
        @(negedge clk); #1;
        ce   = 1'b0;
        snap = {q1_oe, q2_oe, q1_se, q2_se, q1_sp, q2_sp, q1_oa, q2_oa};
        d    = ~d;
        @(posedge clk); #1;
        chk("R7 hold after rising", {q1_oe, q2_oe, q1_se, q2_se, q1_sp, q2_sp, q1_oa, q2_oa}, snap);
        d = ~d ^ 2'b01;
        @(negedge clk); #1;
        chk("R7 hold after falling", {q1_oe, q2_oe, q1_se, q2_se, q1_sp, q2_sp, q1_oa, q2_oa}, snap);
        d = 2'b10;
        @(posedge clk); #1;
        chk("R7 hold second rising", {q1_oe, q2_oe, q1_se, q2_se, q1_sp, q2_sp, q1_oa, q2_oa}, snap);
        ce = 1'b1;
    endtask

    // R5 R6 R8 R9: control priority, timing and levels
    task automatic t_sr_rev();
        logic [W-1:0] q1_hold;
        logic [W-1:0] q2_hold;
        @(negedge clk); #1;
        q1_hold = q1_oe;
        q2_hold = q2_oe;
        ce  = 1'b0;
        sr  = 1'b1;
        rev = 1'b1;
        #0.5;
        chk("R8 sync q1 waits for edge", 16'(q1_oe), 16'(q1_hold));
        chk("R8 async q1 pipe immediate (R5,R9)", 16'(q1_sp), 16'(2'b11));
        chk("R8 async q2 pipe immediate (R5)", 16'(q2_sp), 16'(2'b00));
        chk("R8 async q1 opp lvl0 immediate (R9)", 16'(q1_oa), 16'(2'b11));
        chk("R8 async q2 opp immediate (R5)", 16'(q2_oa), 16'(2'b00));
        @(posedge clk); #1;
        chk("R5 sr beats rev and ce q1 opp-sync", 16'(q1_oe), 16'(2'b00));
        chk("R8 opp-sync q2 waits for falling", 16'(q2_oe), 16'(q2_hold));
        chk("R5 sr q1/q2 same", 16'({q1_se, q2_se}), 16'(4'b0000));
        @(negedge clk); #1;
        chk("R5 sr q2 opp-sync at falling", 16'(q2_oe), 16'(2'b00));
        rev = 1'b0;
        #0.5;
        chk("R5 async stays forced by sr", 16'({q1_sp, q2_sp, q1_oa, q2_oa}), 16'(8'b11001100));
        @(posedge clk); #1;
        @(negedge clk); #1;
        sr = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); #1;
        rev = 1'b1;
        #0.5;
        chk("R8 sync q1 waits for rev edge", 16'(q1_oe), 16'(2'b00));
        chk("R6 async rev q1 pipe lvl0 (R9)", 16'(q1_sp), 16'(2'b00));
        chk("R6 async rev q2 pipe", 16'(q2_sp), 16'(2'b11));
        chk("R6 async rev q1 opp lvl0 (R9)", 16'(q1_oa), 16'(2'b00));
        chk("R6 async rev q2 opp", 16'(q2_oa), 16'(2'b11));
        @(posedge clk); #1;
        chk("R6 rev q1 opp-sync", 16'(q1_oe), 16'(2'b11));
        chk("R6 rev q1/q2 same", 16'({q1_se, q2_se}), 16'(4'b1111));
        @(negedge clk); #1;
        chk("R6 rev q2 opp-sync at falling", 16'(q2_oe), 16'(2'b11));
        rev = 1'b0;
        ce  = 1'b1;
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_stream();
        t_ce_hold();
        t_sr_rev();
        t_stream();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule